// File: doc/BRIEF.md
# Power-of-Two Sample Decimator

This block follows the per-slot burst accumulator of an optical measurement front end. For every time slot it collects a run of N consecutive sample results, where N is two raised to a small per-slot code (so N runs from 1 up to 128). When the Nth sample of a run arrives, it does three things:

- it copies the full-width sum into a readout register;
- it presents the sum divided by N, formed by a right shift, as the word bound for the output FIFO;
- it pulses a one-cycle data-ready strobe.

The running sum and the sample count then restart from zero.

Each slot has a hold input. A read in progress drives it, so that a completing run cannot overwrite the readout register halfway through the read. A completion that falls while hold is high is dropped for the readout register only. It is never deferred. The FIFO word, the strobe and the running accumulation carry on unaffected. Slots are fully independent.

Top module: `smp_decimator`

## Requirements
- R1: After reset, every slot's readout sum, averaged word and ready strobe are zero, and a fresh run begins.
- R2: Slot s reads its code k from bits [3s+2:3s] of `dec_code`. Code k selects a run length of N = 2^k, for every k from 0 to 7.
- R3: `avg_valid[s]` is high for exactly one cycle, the cycle after the clock edge that accepts the Nth valid sample of a run. It is low in all other cycles.
- R4: On the edge that accepts that Nth sample, the slot's readout sum is loaded with the exact sum of the N samples, at full 32-bit width with no truncation. This happens when hold is low.
- R5: On that same edge, the slot's averaged word becomes the run sum shifted right by k, which drops the fraction.
- R6: A completed run clears the sum and the count, so the next run contains only later samples.
- R7: Cycles where a slot's valid bit is low leave its accumulation unchanged, whatever its data input carries.
- R8: If hold is high on the completing edge, the readout sum keeps its old value. That result is discarded: lowering hold later does not change the readout sum until another run completes.
- R9: Hold has no effect on the averaged word, the ready strobe or the running accumulation. A run that straddles a hold period sums all of its samples.
- R10: Slots accumulate and complete independently, each with its own code and hold.
- R11: If the code is lowered while a run is partly gathered, and the count already reaches the new N, the next valid sample completes the run. That sample is included in the sum.
- R12: With code 0, every valid sample completes a run. The averaged word and the readout sum both equal that sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | NUM_SLOTS | Per-slot sample strobe |
| smp_data | input | NUM_SLOTS*SAMPLE_W | Per-slot sample values, slot s at [s*SAMPLE_W +: SAMPLE_W] |
| dec_code | input | NUM_SLOTS*CODE_W | Per-slot log2 run-length code |
| hold | input | NUM_SLOTS | Per-slot freeze of the readout sum |
| sum_reg | output | NUM_SLOTS*SUM_W | Per-slot full-width readout sum |
| avg_word | output | NUM_SLOTS*SAMPLE_W | Per-slot averaged word for the FIFO |
| avg_valid | output | NUM_SLOTS | Per-slot one-cycle data-ready strobe |

## Verification
The bench builds the block with its default parameters: two slots, 20-bit samples, a 32-bit sum and a largest code of 7. These values make the longest run of 128 samples short enough to drive completely. That run is fed with full-scale samples, which carries the sum up to 27 bits and checks that nothing is truncated. With two slots, one code of 2 and one of 1 can run side by side to show independence. Directed scenarios also cover hold across a completing edge, a hold that straddles the middle of a run, a code lowered mid-run, and idle cycles that carry junk data.

// File: rtl/dec_pkg.sv
package dec_pkg;

    // Default geometry of the decimator, shared by every module of the block.
    parameter int DEC_NUM_SLOTS = 2;
    parameter int DEC_SAMPLE_W  = 20;
    parameter int DEC_SUM_W     = 32;
    parameter int DEC_CODE_W    = 3;
    parameter int DEC_MAX_CODE  = 7;

    // Clamp a requested code to the largest supported run length.
    function automatic int unsigned clamp_code(input int unsigned code, input int unsigned max_code);
        return (code > max_code) ? max_code : code;
    endfunction

endpackage

// File: rtl/dec_slot_accum.sv
module dec_slot_accum
    import dec_pkg::*;
#(
    parameter int SAMPLE_W = DEC_SAMPLE_W,
    parameter int SUM_W    = DEC_SUM_W,
    parameter int CODE_W   = DEC_CODE_W,
    parameter int MAX_CODE = DEC_MAX_CODE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [CODE_W-1:0]   code,
    output logic                grp_done,
    output logic [SUM_W-1:0]    grp_total,
    output logic [CODE_W-1:0]   grp_shift
);

    localparam int CNT_W = MAX_CODE + 1;

    typedef struct packed {
        logic [SUM_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] limit;
    logic [SUM_W-1:0] acc_inc;

    always_comb begin
        st_d      = st_q;
        grp_shift = CODE_W'(clamp_code(int'(code), MAX_CODE));
        limit     = CNT_W'(1) << grp_shift;
        cnt_inc   = st_q.cnt + 1'b1;
        acc_inc   = st_q.acc + SUM_W'(smp_data);
        // A lowered code may leave the count already at or past the new limit.
        grp_done  = smp_valid && (cnt_inc >= limit);
        grp_total = acc_inc;
        if (smp_valid) begin
            if (grp_done) begin
                st_d.acc = '0;
                st_d.cnt = '0;
            end else begin
                st_d.acc = acc_inc;
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_clear_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grp_done |=> (st_q.cnt == '0 && st_q.acc == '0));

    assert_idle_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(st_q));

    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < (CNT_W'(1) << MAX_CODE));

    assert_code0_completes_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && code == '0) |=> (st_q.cnt == '0));

endmodule

// File: rtl/dec_readout.sv
module dec_readout
    import dec_pkg::*;
#(
    parameter int SAMPLE_W = DEC_SAMPLE_W,
    parameter int SUM_W    = DEC_SUM_W,
    parameter int CODE_W   = DEC_CODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grp_done,
    input  logic [SUM_W-1:0]    grp_total,
    input  logic [CODE_W-1:0]   grp_shift,
    input  logic                hold,
    output logic [SUM_W-1:0]    sum_out,
    output logic [SAMPLE_W-1:0] avg_out,
    output logic                rdy_out
);

    typedef struct packed {
        logic [SUM_W-1:0]    sum;
        logic [SAMPLE_W-1:0] avg;
        logic                rdy;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    always_comb begin
        rd_d     = rd_q;
        rd_d.rdy = grp_done;
        if (grp_done) begin
            rd_d.avg = SAMPLE_W'(grp_total >> grp_shift);
            // A frozen readout drops this result; nothing is queued.
            if (!hold) begin
                rd_d.sum = grp_total;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign sum_out = rd_q.sum;
    assign avg_out = rd_q.avg;
    assign rdy_out = rd_q.rdy;

    assert_strobe_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grp_done |=> rdy_out);

    assert_no_stray_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_done |=> (!rdy_out && $stable(avg_out) && $stable(sum_out)));

    assert_sum_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_done && !hold) |=> (sum_out == $past(grp_total)));

    assert_avg_scaled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grp_done |=> (avg_out == SAMPLE_W'($past(grp_total) >> $past(grp_shift))));

    assert_hold_freezes_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(sum_out));

endmodule

// File: rtl/smp_decimator.sv
module smp_decimator
    import dec_pkg::*;
#(
    parameter int NUM_SLOTS = DEC_NUM_SLOTS,
    parameter int SAMPLE_W  = DEC_SAMPLE_W,
    parameter int SUM_W     = DEC_SUM_W,
    parameter int CODE_W    = DEC_CODE_W,
    parameter int MAX_CODE  = DEC_MAX_CODE
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SLOTS-1:0]          smp_valid,
    input  logic [NUM_SLOTS*SAMPLE_W-1:0] smp_data,
    input  logic [NUM_SLOTS*CODE_W-1:0]   dec_code,
    input  logic [NUM_SLOTS-1:0]          hold,
    output logic [NUM_SLOTS*SUM_W-1:0]    sum_reg,
    output logic [NUM_SLOTS*SAMPLE_W-1:0] avg_word,
    output logic [NUM_SLOTS-1:0]          avg_valid
);

    genvar s;
    generate
        for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
            logic              done_w;
            logic [SUM_W-1:0]  total_w;
            logic [CODE_W-1:0] shift_w;

            dec_slot_accum #(
                .SAMPLE_W (SAMPLE_W),
                .SUM_W    (SUM_W),
                .CODE_W   (CODE_W),
                .MAX_CODE (MAX_CODE)
            ) u_accum (
                .clk       (clk),
                .rst_n     (rst_n),
                .smp_valid (smp_valid[s]),
                .smp_data  (smp_data[s*SAMPLE_W +: SAMPLE_W]),
                .code      (dec_code[s*CODE_W +: CODE_W]),
                .grp_done  (done_w),
                .grp_total (total_w),
                .grp_shift (shift_w)
            );

            dec_readout #(
                .SAMPLE_W (SAMPLE_W),
                .SUM_W    (SUM_W),
                .CODE_W   (CODE_W)
            ) u_readout (
                .clk       (clk),
                .rst_n     (rst_n),
                .grp_done  (done_w),
                .grp_total (total_w),
                .grp_shift (shift_w),
                .hold      (hold[s]),
                .sum_out   (sum_reg[s*SUM_W +: SUM_W]),
                .avg_out   (avg_word[s*SAMPLE_W +: SAMPLE_W]),
                .rdy_out   (avg_valid[s])
            );

            assert_hold_spares_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (hold[s] && done_w) |=> avg_valid[s]);
        end
    endgenerate

endmodule

// File: tb/smp_decimator_test.sv
module smp_decimator_test;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 2;
    localparam int SW = 20;
    localparam int UW = 32;
    localparam int CW = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NS-1:0]     smp_valid;
    logic [NS*SW-1:0]  smp_data;
    logic [NS*CW-1:0]  dec_code;
    logic [NS-1:0]     hold;
    logic [NS*UW-1:0]  sum_reg;
    logic [NS*SW-1:0]  avg_word;
    logic [NS-1:0]     avg_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smp_decimator uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .dec_code  (dec_code),
        .hold      (hold),
        .sum_reg   (sum_reg),
        .avg_word  (avg_word),
        .avg_valid (avg_valid)
    );

    function automatic logic [UW-1:0] sum_of(int s);
        return sum_reg[s*UW +: UW];
    endfunction

    function automatic logic [SW-1:0] avg_of(int s);
        return avg_word[s*SW +: SW];
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic set_code(input int c0, input int c1);
        dec_code = {CW'(c1), CW'(c0)};
    endtask

    // Drive one cycle at a falling edge; return at the next falling edge with outputs settled.
    task automatic tick(input logic v0, input logic [SW-1:0] d0, input logic v1, input logic [SW-1:0] d1);
        smp_valid = {v1, v0};
        smp_data  = {d1, d0};
        @(posedge clk);
        @(negedge clk);
        smp_valid = '0;
        smp_data  = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        smp_valid = '0;
        smp_data = '0;
        dec_code = '0;
        hold = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_reset();
        do_reset();
        chk("R1", "sum slot0", 64'(sum_of(0)), 0);
        chk("R1", "sum slot1", 64'(sum_of(1)), 0);
        chk("R1", "avg words", 64'(avg_word), 0);
        chk("R1", "ready", 64'(avg_valid), 0);
    endtask

    task automatic test_code0();
        do_reset();
        set_code(0, 0);
        tick(1, 20'h12345, 0, 0);
        chk("R12", "strobe", 64'(avg_valid), 64'b01);
        chk("R12", "avg", 64'(avg_of(0)), 64'h12345);
        chk("R12", "sum", 64'(sum_of(0)), 64'h12345);
        tick(1, 20'h00007, 0, 0);
        chk("R12", "second avg", 64'(avg_of(0)), 64'h7);
    endtask

    task automatic test_two_slots();
        do_reset();
        set_code(2, 1);
        tick(1, 10, 1, 1);
        chk("R3", "no early strobe", 64'(avg_valid), 0);
        tick(1, 20, 1, 2);
        chk("R10", "slot1 only strobe", 64'(avg_valid), 64'b10);
        chk("R5", "slot1 avg 3>>1", 64'(avg_of(1)), 1);
        chk("R4", "slot1 sum", 64'(sum_of(1)), 3);
        tick(1, 30, 1, 3);
        chk("R3", "strobe one cycle", 64'(avg_valid), 0);
        tick(1, 40, 1, 4);
        chk("R10", "both strobe", 64'(avg_valid), 64'b11);
        chk("R4", "slot0 sum", 64'(sum_of(0)), 100);
        chk("R5", "slot0 avg", 64'(avg_of(0)), 25);
        chk("R6", "slot1 second run sum", 64'(sum_of(1)), 7);
        chk("R6", "slot1 second run avg", 64'(avg_of(1)), 3);
        tick(0, 0, 0, 0);
        chk("R3", "strobe drops", 64'(avg_valid), 0);
    endtask

    task automatic test_max_run();
        do_reset();
        set_code(7, 0);
        for (int i = 0; i < 127; i++) begin
            tick(1, 20'hFFFFF, 0, 0);
            if (avg_valid[0]) chk("R2", "strobe before 128th", 1, 0);
        end
        chk("R2", "no strobe after 127", 64'(avg_valid[0]), 0);
        tick(1, 20'hFFFFF, 0, 0);
        chk("R2", "strobe at 128th", 64'(avg_valid[0]), 1);
        chk("R4", "full-width sum", 64'(sum_of(0)), 64'h7FFFF80);
        chk("R5", "avg of 128", 64'(avg_of(0)), 64'hFFFFF);
    endtask

    task automatic test_idle_junk();
        do_reset();
        set_code(1, 1);
        tick(1, 5, 0, 20'hABCDE);
        tick(0, 999, 0, 20'h11111);
        tick(0, 777, 0, 0);
        chk("R7", "no strobe on idle", 64'(avg_valid), 0);
        tick(1, 6, 0, 0);
        chk("R7", "sum ignores idle data", 64'(sum_of(0)), 11);
        chk("R7", "slot1 untouched", 64'(sum_of(1)), 0);
    endtask

    task automatic test_hold();
        do_reset();
        set_code(1, 0);
        tick(1, 8, 0, 0);
        tick(1, 2, 0, 0);
        chk("R4", "pre-hold sum", 64'(sum_of(0)), 10);
        hold = 2'b01;
        tick(1, 5, 0, 0);
        tick(1, 7, 0, 0);
        chk("R9", "strobe under hold", 64'(avg_valid[0]), 1);
        chk("R9", "avg under hold", 64'(avg_of(0)), 6);
        chk("R8", "sum frozen", 64'(sum_of(0)), 10);
        hold = 2'b00;
        tick(0, 0, 0, 0);
        tick(0, 0, 0, 0);
        chk("R8", "dropped result not replayed", 64'(sum_of(0)), 10);
        hold = 2'b01;
        tick(1, 4, 0, 0);
        hold = 2'b00;
        tick(1, 6, 0, 0);
        chk("R9", "run across hold sums all", 64'(sum_of(0)), 10'd10);
        chk("R9", "run across hold avg", 64'(avg_of(0)), 5);
        tick(1, 1, 0, 0);
        tick(1, 1, 0, 0);
        chk("R8", "sum updates after release", 64'(sum_of(0)), 2);
    endtask

    task automatic test_code_drop();
        do_reset();
        set_code(3, 0);
        tick(1, 1, 0, 0);
        tick(1, 1, 0, 0);
        tick(1, 1, 0, 0);
        chk("R11", "no strobe at 3 of 8", 64'(avg_valid), 0);
        set_code(1, 0);
        tick(1, 1, 0, 0);
        chk("R11", "completes after drop", 64'(avg_valid[0]), 1);
        chk("R11", "sum includes sample", 64'(sum_of(0)), 4);
        chk("R11", "avg by new code", 64'(avg_of(0)), 2);
        tick(1, 9, 0, 0);
        chk("R6", "fresh run after drop", 64'(avg_valid[0]), 0);
        tick(1, 3, 0, 0);
        chk("R6", "fresh run sum", 64'(sum_of(0)), 12);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        test_reset();
        test_code0();
        test_two_slots();
        test_max_run();
        test_idle_junk();
        test_hold();
        test_code_drop();
        finish_run();
    end

endmodule